// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 16-bit program counter of a small 8-bit controller core and works out where execution goes after each instruction. At each retirement the core gives it the instruction length, a target kind, the two operand bytes, the accumulator, the data pointer, a condition flag and the value popped from the stack. On the next clock edge the counter moves to the chosen target.

The block forms six kinds of target. Sequential flow adds the length to the counter. A page jump keeps the top five bits of the following instruction's address and puts an 11-bit field in place of the low bits. A long jump loads a full 16-bit address. A relative jump adds a signed byte to the address of the following instruction. An indirect jump adds the accumulator to the data pointer. A return loads the popped address. A conditional instruction whose condition fails falls through to the following instruction. For page and long calls, the block presents the address of the following instruction as two bytes for the stack, low byte first. All address arithmetic wraps inside the 64 KB space.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `pc` reads 0x0000.
- R2: When `step` is low, `pc` keeps its value across the clock edge.
- R3: In this requirement "follow" means `pc` plus the effective length, modulo 65536. The length is `ilen` (1, 2 or 3), and an `ilen` of 0 counts as 1. With `kind`=0 (sequential) and `step` high, the next `pc` is follow.
- R4: With `kind`=1 (page jump), the next `pc` takes bits 15..11 from follow, bits 10..8 from `op_hi[2:0]` and bits 7..0 from `op_lo`.
- R5: With `kind`=2 (long jump), the next `pc` is {`op_hi`,`op_lo`}, with `op_hi` as the high byte.
- R6: With `kind`=3 (relative), the next `pc` is follow plus `op_lo` read as a two's-complement value from -128 to +127, modulo 65536.
- R7: With `kind`=4 (indirect), the next `pc` is `dptr` plus the zero-extended `acc`, modulo 65536.
- R8: With `kind`=5 (return), the next `pc` is `ret_addr`.
- R9: When `cond_en` is high and `cond` is low, the next `pc` is follow for every kind.
- R10: `push_en` is high only when `step` and `is_call` are high and `kind` is 1 or 2. While it is high, `push_lo` and `push_hi` carry the low and high bytes of follow.
- R11: A `kind` of 6 or 7 behaves like sequential flow.
- R12: `pc_next` shows, combinationally, the value that `pc` takes at the next edge when `step` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | An instruction retires this cycle |
| ilen | input | 2 | Instruction length in bytes (0 taken as 1) |
| kind | input | 3 | Target kind: 0 seq, 1 page, 2 long, 3 rel, 4 indirect, 5 return |
| is_call | input | 1 | The page or long transfer is a call |
| cond_en | input | 1 | The transfer depends on `cond` |
| cond | input | 1 | Condition result |
| op_hi | input | 8 | First operand byte |
| op_lo | input | 8 | Second operand byte or relative offset |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| ret_addr | input | 16 | Address popped from the stack |
| pc | output | 16 | Program counter |
| pc_next | output | 16 | Address the counter takes on the next step |
| push_en | output | 1 | Return address is valid for pushing |
| push_lo | output | 8 | Low byte of the return address |
| push_hi | output | 8 | High byte of the return address |

## Verification
The counter is the only state, so a wrong target or a faulty hold shows on `pc` one edge after the step that caused it. It also shows at once on `pc_next`, which is combinational. The cases most likely to expose an error are the ones where the page bits of the following instruction differ from those of the current one, a negative offset that crosses address zero, an indirect sum that passes 0xFFFF, and a call whose return bytes come out swapped. Every one of these differs at the ports within a single cycle.

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int AW = 16,
  parameter int PAGE_W = 11,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [1:0]    ilen,
  input  logic [2:0]    kind,
  input  logic          is_call,
  input  logic          cond_en,
  input  logic          cond,
  input  logic [7:0]    op_hi,
  input  logic [7:0]    op_lo,
  input  logic [7:0]    acc,
  input  logic [AW-1:0] dptr,
  input  logic [AW-1:0] ret_addr,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] pc_next,
  output logic          push_en,
  output logic [7:0]    push_lo,
  output logic [7:0]    push_hi
);
  localparam int HI_W = PAGE_W - 8;
  localparam logic [2:0] K_PAGE = 3'd1, K_LONG = 3'd2, K_REL = 3'd3,
                         K_IND = 3'd4, K_RET = 3'd5;

  logic [AW-1:0] pc_q, follow, t_page, t_long, t_rel, t_ind;
  logic [1:0]    eff_len;
  logic          skip;

  assign eff_len = (ilen == 2'd0) ? 2'd1 : ilen;
  assign follow  = pc_q + AW'(eff_len);
  assign skip    = cond_en & ~cond;

  assign t_page = {follow[AW-1:PAGE_W], op_hi[HI_W-1:0], op_lo};
  assign t_long = AW'({op_hi, op_lo});
  assign t_rel  = follow + {{(AW-8){op_lo[7]}}, op_lo};
  assign t_ind  = dptr + {{(AW-8){1'b0}}, acc};

  always_comb begin
    pc_next = follow;
    if (!skip) begin
      case (kind)
        K_PAGE:  pc_next = t_page;
        K_LONG:  pc_next = t_long;
        K_REL:   pc_next = t_rel;
        K_IND:   pc_next = t_ind;
        K_RET:   pc_next = ret_addr;
        default: pc_next = follow;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pc_q <= RESET_PC[AW-1:0];
    else if (step) pc_q <= pc_next;
  end

  assign pc      = pc_q;
  assign push_en = step & is_call & ((kind == K_PAGE) | (kind == K_LONG));
  assign push_lo = follow[7:0];
  assign push_hi = follow[15:8];
endmodule

// File: rtl/pc_next_unit_check.sv
module pc_next_unit_check (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic [1:0]  ilen,
  input logic [2:0]  kind,
  input logic        is_call,
  input logic        cond_en,
  input logic        cond,
  input logic [7:0]  op_hi,
  input logic [7:0]  op_lo,
  input logic [15:0] pc,
  input logic [15:0] pc_next,
  input logic [15:0] ret_addr,
  input logic        push_en,
  input logic [7:0]  push_lo,
  input logic [7:0]  push_hi
);
  logic [15:0] len16, nxt_seq;
  logic        taken;
  assign len16   = (ilen == 2'd0) ? 16'd1 : {14'd0, ilen};
  assign nxt_seq = pc + len16;
  assign taken   = !(cond_en && !cond);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> pc == $past(pc));
  p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> pc == $past(pc_next));
  p_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !taken) |=> pc == $past(nxt_seq));
  p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == 3'd0) |=> pc == $past(nxt_seq));
  p_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && taken && kind == 3'd2) |=> pc == $past({op_hi, op_lo}));
  p_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && taken && kind == 3'd5) |=> pc == $past(ret_addr));
  p_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && taken && kind == 3'd1) |=> pc[15:11] == $past(nxt_seq[15:11]));
  p_push_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (step && is_call && (kind == 3'd1 || kind == 3'd2)));
  p_push_val_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> {push_hi, push_lo} == nxt_seq);
endmodule

bind pc_next_unit pc_next_unit_check u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .ilen(ilen), .kind(kind),
  .is_call(is_call), .cond_en(cond_en), .cond(cond), .op_hi(op_hi),
  .op_lo(op_lo), .pc(pc), .pc_next(pc_next), .ret_addr(ret_addr),
  .push_en(push_en), .push_lo(push_lo), .push_hi(push_hi)
);

// File: tb/pc_next_unit_test.sv
`timescale 1ns/1ps
module pc_next_unit_test;
  logic clk = 0, rst_n = 0, step = 0, is_call = 0, cond_en = 0, cond = 0;
  logic [1:0] ilen = 1;
  logic [2:0] kind = 0;
  logic [7:0] op_hi = 0, op_lo = 0, acc = 0;
  logic [15:0] dptr = 0, ret_addr = 0;
  logic [15:0] pc, pc_next;
  logic push_en;
  logic [7:0] push_lo, push_hi;
  int total = 0, bad = 0;
  int model_pc = 0;
  bit model_live = 0;

  always #4 clk = ~clk;

  pc_next_unit uut (.clk(clk), .rst_n(rst_n), .step(step), .ilen(ilen), .kind(kind),
    .is_call(is_call), .cond_en(cond_en), .cond(cond), .op_hi(op_hi), .op_lo(op_lo),
    .acc(acc), .dptr(dptr), .ret_addr(ret_addr), .pc(pc), .pc_next(pc_next),
    .push_en(push_en), .push_lo(push_lo), .push_hi(push_hi));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int follow_of(int p, int l);
    return (p + ((l == 0) ? 1 : l)) % 65536;
  endfunction

  function automatic int model_next(int p);
    int f = follow_of(p, ilen);
    int off;
    if (cond_en && !cond) return f;
    case (kind)
      1: return (f / 2048) * 2048 + (op_hi % 8) * 256 + op_lo;
      2: return op_hi * 256 + op_lo;
      3: begin
           off = (op_lo >= 128) ? op_lo - 256 : op_lo;
           return (f + off + 65536) % 65536;
         end
      4: return (dptr + acc) % 65536;
      5: return ret_addr;
      default: return f;
    endcase
  endfunction

  always @(negedge clk) if (model_live) check("R2/R12 pc track", pc, model_pc);

  always @(posedge clk) begin
    if (!rst_n) model_pc <= 0;
    else if (step) model_pc <= model_next(model_pc);
  end

  task automatic op(input string req, input int k, input int l, input int hi, input int lo,
                    input bit ce = 0, input bit c = 0, input bit call = 0);
    int exp;
    @(negedge clk);
    kind = 3'(k); ilen = 2'(l); op_hi = 8'(hi); op_lo = 8'(lo);
    cond_en = ce; cond = c; is_call = call; step = 1;
    #1;
    exp = model_next(model_pc);
    check(req, pc_next, exp);
    check({req, " push_en"}, push_en, call && (k == 1 || k == 2));
    if (push_en) begin
      check({req, " push_lo"}, push_lo, follow_of(pc, l) % 256);
      check({req, " push_hi"}, push_hi, follow_of(pc, l) / 256);
    end
    @(posedge clk); #1;
    step = 0;
    check(req, pc, exp);
  endtask

  task automatic jump_to(input int a);
    op("R5 set", 2, 3, a / 256, a % 256);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset", pc, 0);
    rst_n = 1;
    @(posedge clk); #1 check("R1 after reset", pc, 0);
    model_live = 1;
    repeat (3) @(posedge clk);
    #1 check("R2 hold", pc, 0);
    op("R3 len1", 0, 1, 0, 0);
    op("R3 len2", 0, 2, 0, 0);
    op("R3 len3", 0, 3, 0, 0);
    op("R3 len0", 0, 0, 0, 0);
    jump_to(16'hFFFE);
    op("R3 wrap", 0, 3, 0, 0);
    jump_to(16'h17FF);
    op("R4 page of follow", 1, 2, 8'h05, 8'h22);
    jump_to(16'h27FE);
    op("R4 page boundary", 1, 2, 8'hFF, 8'h10);
    op("R5 long", 2, 3, 8'hBE, 8'hEF);
    jump_to(16'h0002);
    op("R6 neg wrap", 3, 2, 0, 8'hF8);
    jump_to(16'h1000);
    op("R6 +127", 3, 2, 0, 8'h7F);
    op("R6 -128", 3, 2, 0, 8'h80);
    dptr = 16'hFFF0; acc = 8'h20;
    op("R7 wrap", 4, 1, 0, 0);
    dptr = 16'h1234; acc = 8'hFF;
    op("R7 zero-ext", 4, 1, 0, 0);
    ret_addr = 16'hA55A;
    op("R8 ret", 5, 1, 0, 0);
    op("R9 rel not taken", 3, 2, 0, 8'h40, 1, 0);
    op("R9 rel taken", 3, 2, 0, 8'h40, 1, 1);
    op("R9 ind not taken", 4, 1, 0, 0, 1, 0);
    op("R9 long not taken", 2, 3, 8'h11, 8'h22, 1, 0);
    jump_to(16'h12FE);
    op("R10 page call", 1, 2, 8'h03, 8'h44, 0, 0, 1);
    op("R10 long call", 2, 3, 8'h80, 8'h01, 0, 0, 1);
    op("R10 no push on rel", 3, 2, 0, 8'h05, 0, 0, 1);
    op("R11 kind6", 6, 2, 8'h77, 8'h77);
    op("R11 kind7", 7, 3, 8'h77, 8'h77);
    repeat (2) @(posedge clk);
    #1 check("R2 hold end", pc, model_pc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule